// File: doc/BRIEF.md
# Mixed-Signal Capture Trigger Unit

This block decides the moment at which a capture fires. It watches a stream of samples. Each sample pairs a 10-bit analog reading with an 8-bit logic word. Settings live in byte-wide configuration registers that share one write port:

- the analog threshold,
- the edge polarity,
- the trigger mode,
- a logic pattern and its don't-care mask,
- a pulse-width limit,
- a 16-bit holdoff,
- an enable bit.

Writes to the control address carry commands. One command resets the state machine, one arms it, and one forces a trigger at once.

In the analog modes a trigger comes from a threshold crossing. In the two width modes, that crossing also has to bound a pulse whose length in samples passes a comparison against the limit. In pattern mode the analog path is set aside, and the trigger fires on the first sample whose logic word matches the pattern on every channel the mask keeps. Holdoff counts samples after arming, and during holdoff no trigger is taken. After a trigger the unit counts a fixed number of further samples and then reports that the data is ready. The status byte always shows the current phase.

Samples arrive over a valid/ready handshake. The unit never applies back-pressure: `smp_ready` is held high, and a sample is consumed on every clock edge where `smp_valid` is high. Configuration, commands, the trigger pulse and status are plain signals.

Top module: `mstrig_unit`

## Requirements
- R1: After reset, `status` is 0x00 (idle) and `trig_pulse` is 0. All settings reset to zero, except the pattern mask, which resets to 0xFF (all channels ignored).
- R2: The threshold is 10 bits. Its low byte is written at address 3, and its top two bits are bits 1:0 of address 4. A sample counts as above the threshold when it is greater than or equal to the threshold.
- R3: Bit 2 of address 4 selects the edge polarity. With 0, a crossing from below to above is the leading edge. With 1, a crossing from above to below is the leading edge. Mode 00 (bits 6:5 of address 4) fires on the leading edge only. An edge needs a previous sample, and samples are tracked whether or not the unit is armed.
- R4: Mode 01 fires on the trailing edge of a pulse if the pulse width is below the limit at address 11. The width is the number of samples from the leading-edge sample up to, but not including, the trailing-edge sample.
- R5: Mode 10 fires on the trailing edge if the width is greater than or equal to the limit. The width count saturates at 255 instead of wrapping.
- R6: Mode 11 fires on any sample whose logic word equals the pattern (address 5) on every bit where the mask (address 6) is 0. A mask bit of 1 ignores that channel.
- R7: When bit 7 of address 4 is 0, no sample ever causes a trigger. Only the force command can cause one.
- R8: Writing control address 1 with bit 1 set arms the unit, and `status` becomes 0x01. On the next cycle the unit loads the holdoff (address 7 low byte, address 8 high byte). If the holdoff is zero it goes straight to waiting (0x03); otherwise it enters holdoff (0x02). Each valid sample decrements the holdoff, and the unit moves to waiting when the count reaches zero. No sample can trigger before that point.
- R9: Control bit 3 (force) moves the unit from armed, holdoff or waiting to triggered at once. Force has no effect while the unit is idle, triggered or data-ready.
- R10: Control bit 0 returns the unit to idle. It takes priority over arm and force in the same write.
- R11: A trigger raises `trig_pulse` for exactly one cycle, in the cycle after the edge that took the deciding sample or command, and `status` becomes 0x04. After POST_SAMPLES further valid samples, `status` becomes 0x05 (data ready) and stays there until a reset or arm command.
- R12: `smp_ready` is always 1, and every sample presented with `smp_valid` is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Sample accepted (always 1) |
| smp_analog | input | 10 | Analog sample |
| smp_logic | input | 8 | Logic channel sample |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| status | output | 8 | Current phase code |

## Verification
The assertions assume that a control write carries at most one meaningful combination of command bits per cycle. They also assume that the clock keeps running while `smp_valid` is idle, so that holdoff and post-trigger counts advance only on valid samples. The stimulus makes every configuration change while the unit is idle or before it is armed. Each analog scenario opens with a sample on a known side of the threshold, so that the edge tracker and the pulse tracker start from a defined history. The behavioural model in the bench keeps the same history across scenarios, so pulses that straddle a reset or a re-arm stay consistent between model and design.

// File: rtl/mstrig_pkg.sv
package mstrig_pkg;
  localparam int REG_AW   = 4;
  localparam int BYTE_W   = 8;
  localparam int THR_HI_W = 2;
  localparam int THR_W    = BYTE_W + THR_HI_W;
  localparam int LOGIC_W  = BYTE_W;
  localparam int WLIM_W   = BYTE_W;
  localparam int HOLD_W   = 2 * BYTE_W;
  localparam int STATUS_W = BYTE_W;
  localparam int ST_W     = 3;

  // register map; addresses are decoded by the configuration bank
  localparam logic [REG_AW-1:0] ADR_CTRL    = 4'd1;
  localparam logic [REG_AW-1:0] ADR_THR_LO  = 4'd3;
  localparam logic [REG_AW-1:0] ADR_TCFG    = 4'd4;
  localparam logic [REG_AW-1:0] ADR_PAT     = 4'd5;
  localparam logic [REG_AW-1:0] ADR_MASK    = 4'd6;
  localparam logic [REG_AW-1:0] ADR_HOLD_LO = 4'd7;
  localparam logic [REG_AW-1:0] ADR_HOLD_HI = 4'd8;
  localparam logic [REG_AW-1:0] ADR_WLIM    = 4'd11;

  // command bits of the control address
  localparam int CTL_RST   = 0;
  localparam int CTL_ARM   = 1;
  localparam int CTL_FORCE = 3;

  // fields of the trigger configuration byte
  localparam int TC_SLOPE   = 2;
  localparam int TC_MODE_LO = 5;
  localparam int TC_EN      = 7;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_HOLD  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_TRIG  = 3'd4,
    ST_DONE  = 3'd5
  } state_e;

  typedef enum logic [1:0] {
    MD_LEVEL   = 2'd0,
    MD_NARROW  = 2'd1,
    MD_WIDE    = 2'd2,
    MD_PATTERN = 2'd3
  } mode_e;

  typedef struct packed {
    logic [THR_W-1:0]   thr;
    logic               falling;
    mode_e              mode;
    logic               en;
    logic [LOGIC_W-1:0] pat;
    logic [LOGIC_W-1:0] mask;
    logic [WLIM_W-1:0]  wlim;
    logic [HOLD_W-1:0]  hold;
  } cfg_t;
endpackage

// File: rtl/mstrig_cfg.sv
module mstrig_cfg
  import mstrig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_t              cfg,
  output logic              cmd_rst,
  output logic              cmd_arm,
  output logic              cmd_force
);
  localparam int NKEEP       = 7;
  localparam int IX_THR_LO   = 0;
  localparam int IX_TCFG     = 1;
  localparam int IX_PAT      = 2;
  localparam int IX_MASK     = 3;
  localparam int IX_HOLD_LO  = 4;
  localparam int IX_HOLD_HI  = 5;
  localparam int IX_WLIM     = 6;
  localparam logic [REG_AW-1:0] KEEP_ADR [NKEEP] = '{
    ADR_THR_LO, ADR_TCFG, ADR_PAT, ADR_MASK, ADR_HOLD_LO, ADR_HOLD_HI, ADR_WLIM
  };

  logic [BYTE_W-1:0] bank [NKEEP];
  logic              ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NKEEP; i++)
        bank[i] <= (i == IX_MASK) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
    end else if (we) begin
      for (int i = 0; i < NKEEP; i++)
        if (addr == KEEP_ADR[i]) bank[i] <= wdata;
    end
  end

  // commands act in the cycle of the write; nothing is stored for them
  assign ctrl_wr   = we && (addr == ADR_CTRL);
  assign cmd_rst   = ctrl_wr && wdata[CTL_RST];
  assign cmd_arm   = ctrl_wr && wdata[CTL_ARM];
  assign cmd_force = ctrl_wr && wdata[CTL_FORCE];

  always_comb begin
    cfg.thr     = {bank[IX_TCFG][THR_HI_W-1:0], bank[IX_THR_LO]};
    cfg.falling = bank[IX_TCFG][TC_SLOPE];
    cfg.mode    = mode_e'(bank[IX_TCFG][TC_MODE_LO +: 2]);
    cfg.en      = bank[IX_TCFG][TC_EN];
    cfg.pat     = bank[IX_PAT];
    cfg.mask    = bank[IX_MASK];
    cfg.wlim    = bank[IX_WLIM];
    cfg.hold    = {bank[IX_HOLD_HI], bank[IX_HOLD_LO]};
  end
endmodule

// File: rtl/mstrig_level.sv
module mstrig_level
  import mstrig_pkg::*;
#(
  parameter int A_W  = THR_W,
  parameter int WC_W = WLIM_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [A_W-1:0]  smp,
  input  logic [A_W-1:0]  thr,
  input  logic            falling,
  input  mode_e           mode,
  input  logic [WC_W-1:0] wlim,
  output logic            hit,
  output logic [WC_W-1:0] width,
  output logic            in_pulse
);
  localparam logic [WC_W-1:0] W_MAX = {WC_W{1'b1}};
  localparam logic [WC_W-1:0] W_ONE = WC_W'(1);

  logic above, prev_above, have_prev;
  logic rise, fall, lead, trail;

  assign above = (smp >= thr);
  assign rise  = have_prev && !prev_above && above;
  assign fall  = have_prev && prev_above && !above;
  assign lead  = falling ? fall : rise;
  assign trail = falling ? rise : fall;

  always_comb begin
    hit = 1'b0;
    if (take) begin
      unique case (mode)
        MD_LEVEL:  hit = lead;
        MD_NARROW: hit = trail && in_pulse && (width <  wlim);
        MD_WIDE:   hit = trail && in_pulse && (width >= wlim);
        default:   hit = 1'b0;
      endcase
    end
  end

  // edge history and pulse width run on every sample, armed or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_above <= 1'b0;
      have_prev  <= 1'b0;
      in_pulse   <= 1'b0;
      width      <= '0;
    end else if (take) begin
      prev_above <= above;
      have_prev  <= 1'b1;
      if (lead) begin
        in_pulse <= 1'b1;
        width    <= W_ONE;
      end else if (trail) begin
        in_pulse <= 1'b0;
      end else if (in_pulse && (width != W_MAX)) begin
        width <= width + W_ONE;
      end
    end
  end
endmodule

// File: rtl/mstrig_pattern.sv
module mstrig_pattern
  import mstrig_pkg::*;
#(
  parameter int L_W = LOGIC_W
) (
  input  logic [L_W-1:0] smp,
  input  logic [L_W-1:0] pat,
  input  logic [L_W-1:0] mask,
  output logic           hit
);
  logic [L_W-1:0] lane_ok;

  for (genvar b = 0; b < L_W; b++) begin : g_lane
    assign lane_ok[b] = mask[b] || (smp[b] == pat[b]);
  end

  assign hit = &lane_ok;
endmodule

// File: rtl/mstrig_fsm.sv
module mstrig_fsm
  import mstrig_pkg::*;
#(
  parameter int POST_SAMPLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rst,
  input  logic              cmd_arm,
  input  logic              cmd_force,
  input  logic              take,
  input  logic              event_hit,
  input  logic [HOLD_W-1:0] hold,
  output state_e            state,
  output logic              trig_pulse
);
  // POST_SAMPLES must be at least 1
  localparam int PC_W = $clog2(POST_SAMPLES + 1);
  localparam logic [PC_W-1:0]   POST_LOAD = PC_W'(POST_SAMPLES);
  localparam logic [PC_W-1:0]   PC_ONE    = PC_W'(1);
  localparam logic [HOLD_W-1:0] HC_ONE    = HOLD_W'(1);

  state_e            nxt;
  logic [HOLD_W-1:0] hold_cnt, hold_nxt;
  logic [PC_W-1:0]   post_cnt, post_nxt;
  logic              fire;
  logic              forceable;

  assign forceable = (state == ST_ARMED) || (state == ST_HOLD) || (state == ST_WAIT);

  always_comb begin
    nxt      = state;
    hold_nxt = hold_cnt;
    post_nxt = post_cnt;
    fire     = 1'b0;
    if (cmd_rst) begin
      nxt = ST_IDLE;
    end else if (cmd_arm) begin
      nxt = ST_ARMED;
    end else if (cmd_force && forceable) begin
      nxt      = ST_TRIG;
      fire     = 1'b1;
      post_nxt = POST_LOAD;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (hold == '0) begin
            nxt = ST_WAIT;
          end else begin
            nxt      = ST_HOLD;
            hold_nxt = hold;
          end
        end
        ST_HOLD: begin
          if (take) begin
            if (hold_cnt == HC_ONE) nxt = ST_WAIT;
            else hold_nxt = hold_cnt - HC_ONE;
          end
        end
        ST_WAIT: begin
          if (event_hit) begin
            nxt      = ST_TRIG;
            fire     = 1'b1;
            post_nxt = POST_LOAD;
          end
        end
        ST_TRIG: begin
          if (take) begin
            if (post_cnt == PC_ONE) nxt = ST_DONE;
            else post_nxt = post_cnt - PC_ONE;
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hold_cnt   <= '0;
      post_cnt   <= '0;
      trig_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      hold_cnt   <= hold_nxt;
      post_cnt   <= post_nxt;
      trig_pulse <= fire;
    end
  end
endmodule

// File: rtl/mstrig_unit.sv
module mstrig_unit
  import mstrig_pkg::*;
#(
  parameter int POST_SAMPLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [REG_AW-1:0]   cfg_addr,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [THR_W-1:0]    smp_analog,
  input  logic [LOGIC_W-1:0]  smp_logic,
  output logic                trig_pulse,
  output logic [STATUS_W-1:0] status
);
  cfg_t              cfg;
  logic              cmd_rst, cmd_arm, cmd_force;
  logic              take;
  logic              lvl_hit, pat_hit, event_hit;
  logic [WLIM_W-1:0] lvl_width;
  logic              lvl_in_pulse;
  state_e            state;

  assign smp_ready = 1'b1;
  assign take      = smp_valid && smp_ready;

  mstrig_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .cmd_rst  (cmd_rst),
    .cmd_arm  (cmd_arm),
    .cmd_force(cmd_force)
  );

  mstrig_level #(.A_W(THR_W), .WC_W(WLIM_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .smp     (smp_analog),
    .thr     (cfg.thr),
    .falling (cfg.falling),
    .mode    (cfg.mode),
    .wlim    (cfg.wlim),
    .hit     (lvl_hit),
    .width   (lvl_width),
    .in_pulse(lvl_in_pulse)
  );

  mstrig_pattern #(.L_W(LOGIC_W)) u_pattern (
    .smp (smp_logic),
    .pat (cfg.pat),
    .mask(cfg.mask),
    .hit (pat_hit)
  );

  assign event_hit = cfg.en && take &&
                     ((cfg.mode == MD_PATTERN) ? pat_hit : lvl_hit);

  mstrig_fsm #(.POST_SAMPLES(POST_SAMPLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rst   (cmd_rst),
    .cmd_arm   (cmd_arm),
    .cmd_force (cmd_force),
    .take      (take),
    .event_hit (event_hit),
    .hold      (cfg.hold),
    .state     (state),
    .trig_pulse(trig_pulse)
  );

  assign status = {{(STATUS_W-ST_W){1'b0}}, state};
endmodule

// File: rtl/mstrig_checker.sv
module mstrig_checker
  import mstrig_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [REG_AW-1:0]   cfg_addr,
  input logic [BYTE_W-1:0]   cfg_wdata,
  input logic                smp_ready,
  input logic                trig_pulse,
  input logic [STATUS_W-1:0] status,
  input logic [WLIM_W-1:0]   width,
  input logic                in_pulse
);
  localparam logic [STATUS_W-1:0] S_IDLE  = STATUS_W'(ST_IDLE);
  localparam logic [STATUS_W-1:0] S_ARMED = STATUS_W'(ST_ARMED);
  localparam logic [STATUS_W-1:0] S_HOLD  = STATUS_W'(ST_HOLD);
  localparam logic [STATUS_W-1:0] S_TRIG  = STATUS_W'(ST_TRIG);
  localparam logic [STATUS_W-1:0] S_DONE  = STATUS_W'(ST_DONE);
  localparam logic [WLIM_W-1:0]   W_MAX   = {WLIM_W{1'b1}};
  localparam logic [WLIM_W-1:0]   W_ONE   = WLIM_W'(1);

  logic ctrl_wr;
  assign ctrl_wr = cfg_we && (cfg_addr == ADR_CTRL);

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n) smp_ready);

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  p_pulse_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (status == S_TRIG));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == S_DONE) && !(ctrl_wr && (cfg_wdata[CTL_RST] || cfg_wdata[CTL_ARM])))
    |=> (status == S_DONE));

  p_rst_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cfg_wdata[CTL_RST]) |=> (status == S_IDLE));

  p_arm_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !cfg_wdata[CTL_RST] && cfg_wdata[CTL_ARM]) |=> (status == S_ARMED));

  p_holdoff_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == S_HOLD) && !(ctrl_wr && cfg_wdata[CTL_FORCE])) |=> !trig_pulse);

  p_idle_no_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_IDLE) |=> !trig_pulse);

  p_width_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (width == W_MAX) |=> ((width == W_MAX) || (width == W_ONE)));

  p_width_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pulse) |-> (width == W_ONE));
endmodule

bind mstrig_unit mstrig_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .smp_ready (smp_ready),
  .trig_pulse(trig_pulse),
  .status    (status),
  .width     (lvl_width),
  .in_pulse  (lvl_in_pulse)
);

// File: tb/test_mstrig_unit.sv
module test_mstrig_unit;
  localparam int CLK_PERIOD = 10;
  localparam int POST       = 8;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_analog = '0;
  logic [7:0] smp_logic = '0;
  logic       trig_pulse;
  logic [7:0] status;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  mstrig_unit #(.POST_SAMPLES(POST)) i_mstrig_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_analog(smp_analog), .smp_logic(smp_logic),
    .trig_pulse(trig_pulse), .status(status)
  );

  // ---------------- behavioural reference model ----------------
  int mreg [16];
  int m_state, m_hold, m_post, m_width;
  bit m_pulse, m_prev_above, m_have_prev, m_in_pulse;
  int thr, mode, lim, hold_v, a_in, l_in;
  bit falling, en, above, rise_e, fall_e, lead, trail, ev, c_rst, c_arm, c_force;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mreg[k]) mreg[k] = 0;
      mreg[6] = 255;
      m_state = 0; m_hold = 0; m_post = 0; m_width = 0;
      m_pulse = 0; m_prev_above = 0; m_have_prev = 0; m_in_pulse = 0;
    end else begin
      thr     = mreg[3] + (mreg[4] % 4) * 256;
      falling = (mreg[4] / 4) % 2;
      mode    = (mreg[4] / 32) % 4;
      en      = mreg[4] >= 128;
      lim     = mreg[11];
      hold_v  = mreg[7] + mreg[8] * 256;
      c_rst   = cfg_we && cfg_addr == 1 && cfg_wdata[0];
      c_arm   = cfg_we && cfg_addr == 1 && cfg_wdata[1];
      c_force = cfg_we && cfg_addr == 1 && cfg_wdata[3];
      ev = 0;
      if (smp_valid) begin
        a_in = int'(smp_analog);
        l_in = int'(smp_logic);
        above  = a_in >= thr;
        rise_e = m_have_prev && !m_prev_above && above;
        fall_e = m_have_prev && m_prev_above && !above;
        lead   = falling ? fall_e : rise_e;
        trail  = falling ? rise_e : fall_e;
        case (mode)
          0: ev = lead;
          1: ev = trail && m_in_pulse && (m_width < lim);
          2: ev = trail && m_in_pulse && (m_width >= lim);
          default: ev = (((l_in ^ mreg[5]) & ~mreg[6]) & 255) == 0;
        endcase
        if (lead) begin m_in_pulse = 1; m_width = 1; end
        else if (trail) m_in_pulse = 0;
        else if (m_in_pulse && m_width < 255) m_width++;
        m_prev_above = above;
        m_have_prev = 1;
      end
      ev = ev && en;
      m_pulse = 0;
      if (c_rst) m_state = 0;
      else if (c_arm) m_state = 1;
      else if (c_force && m_state >= 1 && m_state <= 3) begin
        m_state = 4; m_pulse = 1; m_post = POST;
      end else begin
        case (m_state)
          1: if (hold_v == 0) m_state = 3; else begin m_state = 2; m_hold = hold_v; end
          2: if (smp_valid) begin if (m_hold == 1) m_state = 3; else m_hold--; end
          3: if (ev) begin m_state = 4; m_pulse = 1; m_post = POST; end
          4: if (smp_valid) begin if (m_post == 1) m_state = 5; else m_post--; end
          default: ;
        endcase
      end
      if (cfg_we && cfg_addr != 1) mreg[cfg_addr] = int'(cfg_wdata);
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (trig_pulse !== m_pulse || status !== 8'(m_state)) begin
        errors++;
        $display("FAIL %s cycle compare: actual trig=%0d status=%0h expected trig=%0d status=%0h",
                 cur_req, trig_pulse, status, m_pulse, m_state);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic smp(input int a, input int l);
    smp_valid = 1'b1; smp_analog = 10'(a); smp_logic = 8'(l);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic arm_seq();
    wr(1, 1); wr(1, 2); wr(1, 0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", int'(status), 0);
    chk("R1 trig", int'(trig_pulse), 0);
    chk("R12 ready", int'(smp_ready), 1);

    // R2 / R11: rising edge at a 10-bit threshold of 0x1A5
    cur_req = "R2";
    wr(3, 'hA5); wr(4, 'h81); wr(7, 0); wr(8, 0);
    smp('h100, 0);
    arm_seq();
    chk("R8 zero holdoff waits", int'(status), 3);
    smp('h1A4, 0);
    chk("R2 just below no trig", int'(trig_pulse), 0);
    smp('h1A5, 0);
    chk("R2 equal fires", int'(trig_pulse), 1);
    chk("R11 triggered code", int'(status), 4);
    smp(0, 0);
    chk("R11 single pulse", int'(trig_pulse), 0);
    for (int i = 0; i < POST - 2; i++) smp(0, 0);
    chk("R11 still triggered", int'(status), 4);
    smp(0, 0);
    chk("R11 data ready", int'(status), 5);
    smp('h3FF, 0);
    chk("R11 sticky ready", int'(status), 5);

    // R3: falling polarity, rising crossing ignored
    cur_req = "R3";
    wr(4, 'h85);
    smp(0, 0);
    arm_seq();
    smp('h3FF, 0);
    chk("R3 rise ignored when falling", int'(trig_pulse), 0);
    smp('h010, 0);
    chk("R3 falling fires", int'(trig_pulse), 1);

    // R4: narrow pulse qualification, limit 3
    cur_req = "R4";
    wr(3, 'h80); wr(4, 'hA0); wr(11, 3);
    smp(0, 0);
    arm_seq();
    for (int i = 0; i < 5; i++) smp(200, 0);
    smp(0, 0);
    chk("R4 width 5 rejected", int'(trig_pulse), 0);
    smp(200, 0); smp(200, 0); smp(0, 0);
    chk("R4 width 2 fires", int'(trig_pulse), 1);

    // R5: wide pulse qualification and saturation
    cur_req = "R5";
    wr(1, 1); wr(4, 'hC0); wr(11, 4);
    smp(0, 0);
    arm_seq();
    for (int i = 0; i < 3; i++) smp(200, 0);
    smp(0, 0);
    chk("R5 width 3 rejected", int'(trig_pulse), 0);
    for (int i = 0; i < 4; i++) smp(200, 0);
    smp(0, 0);
    chk("R5 width 4 fires", int'(trig_pulse), 1);
    wr(11, 255);
    arm_seq();
    for (int i = 0; i < 300; i++) smp(200, 0);
    smp(0, 0);
    chk("R5 saturated width fires", int'(trig_pulse), 1);

    // R6: masked logic pattern
    cur_req = "R6";
    wr(1, 1); wr(4, 'hE0); wr(5, 'hA0); wr(6, 'h0F);
    arm_seq();
    smp(0, 'h20);
    chk("R6 mismatch bit7", int'(trig_pulse), 0);
    smp(0, 'h5A);
    chk("R6 mismatch upper", int'(trig_pulse), 0);
    smp(0, 'hA7);
    chk("R6 masked match fires", int'(trig_pulse), 1);

    // R7: disabled trigger, only force can fire
    cur_req = "R7";
    wr(1, 1); wr(4, 'h60); wr(6, 'hFF);
    arm_seq();
    for (int i = 0; i < 5; i++) smp(i * 100, i);
    chk("R7 disabled no trig", int'(trig_pulse), 0);
    chk("R7 still waiting", int'(status), 3);
    wr(1, 8);
    chk("R9 force while waiting", int'(trig_pulse), 1);
    chk("R9 force state", int'(status), 4);

    // R8: holdoff in samples, low and high byte
    cur_req = "R8";
    wr(1, 1); wr(4, 'hE0); wr(6, 'hFF); wr(7, 3); wr(8, 0);
    wr(1, 1); wr(1, 2);
    chk("R8 armed code", int'(status), 1);
    wr(1, 0);
    chk("R8 holdoff code", int'(status), 2);
    smp(0, 0); smp(0, 0);
    chk("R8 holdoff quiet", int'(trig_pulse), 0);
    chk("R8 holdoff remains", int'(status), 2);
    smp(0, 0);
    chk("R8 holdoff sample no trig", int'(trig_pulse), 0);
    chk("R8 waiting after holdoff", int'(status), 3);
    smp(0, 0);
    chk("R8 first eligible sample fires", int'(trig_pulse), 1);
    wr(7, 0); wr(8, 1);
    arm_seq();
    for (int i = 0; i < 255; i++) smp(0, 0);
    chk("R8 high byte holdoff", int'(status), 2);
    smp(0, 0);
    chk("R8 high byte expires", int'(status), 3);

    // R9: force ignored when idle, accepted in holdoff
    cur_req = "R9";
    wr(1, 1); wr(1, 8);
    chk("R9 idle force ignored trig", int'(trig_pulse), 0);
    chk("R9 idle force ignored state", int'(status), 0);
    wr(7, 3); wr(8, 0);
    arm_seq();
    wr(1, 8);
    chk("R9 force in holdoff", int'(trig_pulse), 1);

    // R10: reset command priority
    cur_req = "R10";
    wr(1, 1);
    chk("R10 reset to idle", int'(status), 0);
    arm_seq();
    wr(1, 'h0B);
    chk("R10 reset beats arm and force", int'(status), 0);
    chk("R10 no pulse", int'(trig_pulse), 0);

    @(negedge clk);
    finish_run();
  end
endmodule